// File: doc/BRIEF.md
# SDRAM Bank Window Decoder

This block keeps the address map of four SDRAM banks and turns every incoming physical address into a bank selection. Each bank has one 32-bit configuration word that packs an enable flag, a base field and a size code. A 34-bit physical address is compared against every enabled bank window at the same time. The block returns a hit flag, the index of the selected bank and the byte offset of the address inside that bank's window.

Software reaches the configuration words over a simple control-register bus made of a write strobe, a register number, write data and combinational read data. Each bank word has its own direct register number. The same words can also be reached through an index/data pair that opens an extended configuration space. That space also holds a fixed, read-only word that reports the memory type. Register writes take effect at the next rising clock edge. The decode path is purely combinational from the address input and the stored words.

Top module: `sdram_bank_decoder`

## Requirements
- R1: Asynchronous active-low reset clears all four bank words and the 8-bit index register to zero. No address hits while the banks hold these values.
- R2: A write to a bank word stores only the bits selected by 0xFFE0FFC1. Every other bit reads back as zero.
- R3: Bit 0 of a bank word is its enable. A bank whose enable is clear never produces a hit.
- R4: Bits 31:21 of a bank word form the base. The physical base is those 11 bits placed at address bits 33:23, so a bank can sit above 4 GiB.
- R5: Bits 15:6 hold a size code c. A code of zero means the bank has no size and never hits. Otherwise the window holds 2^(22+1024-c) bytes, capped at the full 2^34 space (c=1023 gives 8 MiB). An address hits when its bits above the window size equal those of the base.
- R6: Reading a bank word whose size code is zero returns 0x00000000, through either access path.
- R7: When several enabled windows contain the address, the bank with the lowest index is reported.
- R8: On a hit, the offset output equals the address bits below the window size and is zero above them. With no hit, the hit flag, bank index and offset are all zero.
- R9: Register number 0x010 is the index register. A write keeps data bits 7:0, and a read returns the index zero-extended to 32 bits.
- R10: Register number 0x011 is the data window. While the index is 0xE1 it reads 0x20000000, which is the DDR1 type encoding in bits 30:29. Writes at that index change nothing.
- R11: Through the data window, indices 0 to 3 read and write bank words 0 to 3 with the same mask and read rule as direct access.
- R12: Register numbers 0x040 to 0x043 access bank words 0 to 3 directly. All other register numbers, and all other indices in the data window, read zero and ignore writes.
- R13: A register write changes the decode and the read data only from the clock edge that captures it. The decode follows the address input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_num_i | input | 10 | Control-register number |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_num_i (combinational) |
| phys_addr_i | input | 34 | Physical address to decode |
| hit_o | output | 1 | Address falls in an enabled bank window |
| bank_o | output | 2 | Index of the selected bank |
| offset_o | output | 34 | Byte offset inside the selected window |

## Verification
The decode is combinational, so a corrupted bank word shows up in the same cycle as a wrong hit, bank or offset for any address near that bank. It also shows up as a wrong read-back the first time the word is addressed. A wrong index register shows up one access later, when data-window reads or writes reach the wrong word. A mismatch like that can stay hidden until software touches that index. For this reason the reference model compares the read data and all three decode outputs on every clock, not only at explicit checkpoints. Boundary addresses on both sides of each window, overlapping windows and a window above 4 GiB are driven on purpose, so that off-by-one errors in the size shift or the base placement become visible.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  localparam int ADDR_W    = 34;
  localparam int WORD_W    = 32;
  localparam int EN_BIT    = 0;
  localparam int BASE_HI   = 31;
  localparam int BASE_LO   = 21;
  localparam int BASE_W    = BASE_HI - BASE_LO + 1;
  localparam int BASE_LSB  = ADDR_W - BASE_W;          // 23: 8 MiB granule
  localparam int CODE_HI   = 15;
  localparam int CODE_LO   = 6;
  localparam int CODE_W    = CODE_HI - CODE_LO + 1;
  localparam int CODE_SPAN = 1 << CODE_W;              // 1024
  localparam int MIN_LOG2  = BASE_LSB - 1;             // shift 1 -> 8 MiB
  localparam int SPAN_LOG2 = ADDR_W - MIN_LOG2;        // shift at which window fills space

  localparam logic [WORD_W-1:0] WMASK         = 32'hFFE0_FFC1;
  localparam logic [WORD_W-1:0] DDR_MODE_WORD = 32'h2000_0000;
  localparam int                DDR_MODE_IDX  = 'hE1;

  typedef logic [WORD_W-1:0] bank_word_t;
  typedef logic [ADDR_W-1:0] paddr_t;

  function automatic bank_word_t visible_word(bank_word_t w);
    return (w[CODE_HI:CODE_LO] == '0) ? '0 : w;
  endfunction
endpackage

// File: rtl/sdram_bank_regs.sv
module sdram_bank_regs
  import sdram_dec_pkg::*;
#(
  parameter int N_BANKS      = 4,
  parameter int REGNUM_W     = 10,
  parameter int IDX_W        = 8,
  parameter int CFG_ADDR_NUM = 'h010,
  parameter int CFG_DATA_NUM = 'h011,
  parameter int BANK_NUM0    = 'h040,
  localparam int BSEL_W      = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           reg_we_i,
  input  logic [REGNUM_W-1:0]            reg_num_i,
  input  logic [WORD_W-1:0]              reg_wdata_i,
  output logic [WORD_W-1:0]              reg_rdata_o,
  output logic [N_BANKS-1:0][WORD_W-1:0] bank_cfg_o,
  output logic [IDX_W-1:0]               cfg_idx_o
);
  localparam logic [REGNUM_W-1:0] ADDR_NUM_L = REGNUM_W'(CFG_ADDR_NUM);
  localparam logic [REGNUM_W-1:0] DATA_NUM_L = REGNUM_W'(CFG_DATA_NUM);
  localparam logic [REGNUM_W-1:0] BANK_NUM_L = REGNUM_W'(BANK_NUM0);

  logic [IDX_W-1:0]    cfg_idx_q;
  logic [REGNUM_W-1:0] direct_off;
  logic                direct_sel;
  logic                ind_data;
  logic                ind_bank;
  logic                ind_ddr;

  assign direct_off = reg_num_i - BANK_NUM_L;
  assign direct_sel = (reg_num_i >= BANK_NUM_L) && (direct_off < REGNUM_W'(N_BANKS));
  assign ind_data   = (reg_num_i == DATA_NUM_L);
  assign ind_bank   = ind_data && (cfg_idx_q < IDX_W'(N_BANKS));
  assign ind_ddr    = ind_data && (cfg_idx_q == IDX_W'(DDR_MODE_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cfg_idx_q <= '0;
    else if (reg_we_i && reg_num_i == ADDR_NUM_L)  cfg_idx_q <= reg_wdata_i[IDX_W-1:0];
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic             wr_sel;
    logic [WORD_W-1:0] word_q;

    assign wr_sel = reg_we_i &&
                    ((direct_sel && direct_off == REGNUM_W'(b)) ||
                     (ind_bank && cfg_idx_q == IDX_W'(b)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     word_q <= '0;
      else if (wr_sel) word_q <= reg_wdata_i & WMASK;
    end

    assign bank_cfg_o[b] = word_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_num_i == ADDR_NUM_L)
      reg_rdata_o = {{(WORD_W-IDX_W){1'b0}}, cfg_idx_q};
    else if (direct_sel)
      reg_rdata_o = visible_word(bank_cfg_o[direct_off[BSEL_W-1:0]]);
    else if (ind_bank)
      reg_rdata_o = visible_word(bank_cfg_o[cfg_idx_q[BSEL_W-1:0]]);
    else if (ind_ddr)
      reg_rdata_o = DDR_MODE_WORD;
  end

  assign cfg_idx_o = cfg_idx_q;
endmodule

// File: rtl/sdram_window_match.sv
module sdram_window_match
  import sdram_dec_pkg::*;
(
  input  logic [WORD_W-1:0] cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              match_o,
  output logic [ADDR_W-1:0] offset_o
);
  logic [CODE_W-1:0] code;
  logic [CODE_W:0]   shamt;
  logic              sized;
  paddr_t            win_mask;
  paddr_t            base;
  logic              unused_cfg;

  assign code  = cfg_i[CODE_HI:CODE_LO];
  assign sized = (code != '0);
  assign shamt = (CODE_W+1)'(CODE_SPAN) - {1'b0, code};
  assign base  = {cfg_i[BASE_HI:BASE_LO], {BASE_LSB{1'b0}}};

  always_comb begin
    if (shamt >= (CODE_W+1)'(SPAN_LOG2)) win_mask = '1;
    else win_mask = (paddr_t'(1) << (MIN_LOG2 + int'(shamt))) - paddr_t'(1);
  end

  // aligned compare: base bits inside the window are don't-care
  assign match_o  = cfg_i[EN_BIT] && sized && ((addr_i & ~win_mask) == (base & ~win_mask));
  assign offset_o = addr_i & win_mask;

  assign unused_cfg = ^{cfg_i[BASE_LO-1:CODE_HI+1], cfg_i[CODE_LO-1:EN_BIT+1]};
endmodule

// File: rtl/sdram_bank_prio.sv
module sdram_bank_prio
  import sdram_dec_pkg::*;
#(
  parameter int N_BANKS = 4,
  localparam int BSEL_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic [N_BANKS-1:0]             match_i,
  input  logic [N_BANKS-1:0][ADDR_W-1:0] offs_i,
  output logic                           hit_o,
  output logic [BSEL_W-1:0]              bank_o,
  output logic [ADDR_W-1:0]              offset_o
);
  always_comb begin
    bank_o   = '0;
    offset_o = '0;
    // scan downward so the lowest matching index is left standing
    for (int i = N_BANKS - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        bank_o   = BSEL_W'(i);
        offset_o = offs_i[i];
      end
    end
  end

  assign hit_o = |match_i;
endmodule

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder
  import sdram_dec_pkg::*;
#(
  parameter int N_BANKS      = 4,
  parameter int REGNUM_W     = 10,
  parameter int IDX_W        = 8,
  parameter int CFG_ADDR_NUM = 'h010,
  parameter int CFG_DATA_NUM = 'h011,
  parameter int BANK_NUM0    = 'h040,
  localparam int BSEL_W      = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [REGNUM_W-1:0] reg_num_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  input  logic [ADDR_W-1:0]   phys_addr_i,
  output logic                hit_o,
  output logic [BSEL_W-1:0]   bank_o,
  output logic [ADDR_W-1:0]   offset_o
);
  logic [N_BANKS-1:0][WORD_W-1:0] bank_cfg;
  logic [IDX_W-1:0]               cfg_idx;
  logic [N_BANKS-1:0]             match_vec;
  logic [N_BANKS-1:0][ADDR_W-1:0] win_off;

  sdram_bank_regs #(
    .N_BANKS      (N_BANKS),
    .REGNUM_W     (REGNUM_W),
    .IDX_W        (IDX_W),
    .CFG_ADDR_NUM (CFG_ADDR_NUM),
    .CFG_DATA_NUM (CFG_DATA_NUM),
    .BANK_NUM0    (BANK_NUM0)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_num_i   (reg_num_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .bank_cfg_o  (bank_cfg),
    .cfg_idx_o   (cfg_idx)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_match
    sdram_window_match u_match (
      .cfg_i    (bank_cfg[b]),
      .addr_i   (phys_addr_i),
      .match_o  (match_vec[b]),
      .offset_o (win_off[b])
    );
  end

  sdram_bank_prio #(.N_BANKS(N_BANKS)) u_prio (
    .match_i  (match_vec),
    .offs_i   (win_off),
    .hit_o    (hit_o),
    .bank_o   (bank_o),
    .offset_o (offset_o)
  );
endmodule

// File: rtl/sdram_bank_decoder_chk.sv
module sdram_bank_decoder_chk
  import sdram_dec_pkg::*;
#(
  parameter int N_BANKS      = 4,
  parameter int REGNUM_W     = 10,
  parameter int IDX_W        = 8,
  parameter int CFG_ADDR_NUM = 'h010,
  parameter int CFG_DATA_NUM = 'h011,
  parameter int BANK_NUM0    = 'h040,
  localparam int BSEL_W      = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           reg_we_i,
  input logic [REGNUM_W-1:0]            reg_num_i,
  input logic [WORD_W-1:0]              reg_wdata_i,
  input logic [WORD_W-1:0]              reg_rdata_o,
  input logic [ADDR_W-1:0]              phys_addr_i,
  input logic                           hit_o,
  input logic [BSEL_W-1:0]              bank_o,
  input logic [ADDR_W-1:0]              offset_o,
  input logic [N_BANKS-1:0][WORD_W-1:0] bank_cfg_i,
  input logic [IDX_W-1:0]               cfg_idx_i,
  input logic [N_BANKS-1:0]             match_i
);
  AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> bank_cfg_i[bank_o][EN_BIT]);  // R3

  AST_HIT_NEEDS_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (bank_cfg_i[bank_o][CODE_HI:CODE_LO] != '0));  // R5

  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_i[bank_o] &&
               ((match_i & ((N_BANKS'(1) << bank_o) - N_BANKS'(1))) == '0)));  // R7

  AST_OFFSET_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (offset_o <= phys_addr_i));  // R8

  AST_WRITE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_num_i == REGNUM_W'(BANK_NUM0))
      |=> (bank_cfg_i[0] == ($past(reg_wdata_i) & WMASK)));  // R2

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_num_i == REGNUM_W'(CFG_ADDR_NUM)) |=> $stable(cfg_idx_i));  // R9

  AST_DDR_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_num_i == REGNUM_W'(CFG_DATA_NUM) && cfg_idx_i == IDX_W'(DDR_MODE_IDX))
      |-> (reg_rdata_o == DDR_MODE_WORD));  // R10

  AST_ZERO_SIZE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_num_i == REGNUM_W'(BANK_NUM0) && bank_cfg_i[0][CODE_HI:CODE_LO] == '0)
      |-> (reg_rdata_o == '0));  // R6
endmodule

bind sdram_bank_decoder sdram_bank_decoder_chk #(
  .N_BANKS      (N_BANKS),
  .REGNUM_W     (REGNUM_W),
  .IDX_W        (IDX_W),
  .CFG_ADDR_NUM (CFG_ADDR_NUM),
  .CFG_DATA_NUM (CFG_DATA_NUM),
  .BANK_NUM0    (BANK_NUM0)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_num_i   (reg_num_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .phys_addr_i (phys_addr_i),
  .hit_o       (hit_o),
  .bank_o      (bank_o),
  .offset_o    (offset_o),
  .bank_cfg_i  (bank_cfg),
  .cfg_idx_i   (cfg_idx),
  .match_i     (match_vec)
);

// File: tb/sdram_bank_decoder_test.sv
`timescale 1ns/1ps
module sdram_bank_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  num = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [33:0] addr = '0;
  logic        hit;
  logic [1:0]  bank;
  logic [33:0] off;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  sdram_bank_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_num_i(num),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .phys_addr_i(addr),
    .hit_o(hit), .bank_o(bank), .offset_o(off)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_bank [4];
  logic [7:0]  m_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_bank[i] <= '0;
      m_idx <= '0;
    end else if (we) begin
      if (num == 10'h010) m_idx <= wdata[7:0];
      else if (num >= 10'h040 && num <= 10'h043) m_bank[int'(num) - 'h40] <= wdata & 32'hFFE0_FFC1;
      else if (num == 10'h011 && m_idx < 8'd4) m_bank[m_idx] <= wdata & 32'hFFE0_FFC1;
    end
  end

  function automatic logic [31:0] shown(logic [31:0] w);
    return (((w >> 6) & 32'h3FF) == 0) ? 32'h0 : w;
  endfunction

  function automatic logic [31:0] exp_rdata(logic [9:0] n);
    if (n == 10'h010) return {24'h0, m_idx};
    if (n >= 10'h040 && n <= 10'h043) return shown(m_bank[int'(n) - 'h40]);
    if (n == 10'h011) begin
      if (m_idx < 8'd4) return shown(m_bank[m_idx]);
      if (m_idx == 8'hE1) return 32'h2000_0000;
    end
    return 32'h0;
  endfunction

  function automatic logic [36:0] exp_decode(logic [33:0] a);
    longint unsigned mask, base, aa;
    int code, lg;
    logic [36:0] r;
    r = '0;
    aa = longint'(a);
    for (int i = 3; i >= 0; i--) begin
      code = int'((m_bank[i] >> 6) & 32'h3FF);
      if (m_bank[i][0] && code != 0) begin
        lg = 22 + 1024 - code;
        if (lg > 34) lg = 34;
        mask = (64'd1 << lg) - 64'd1;
        base = longint'(m_bank[i][31:21]) << 23;
        if (((aa ^ base) & ~mask & 64'h3_FFFF_FFFF) == 0)
          r = {1'b1, 2'(i), 34'(aa & mask)};
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 R7 R8 decode", 64'({hit, bank, off}), 64'(exp_decode(addr)));
      check("R2 R6 R9 R10 R11 R12 readback", 64'(rdata), 64'(exp_rdata(num)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [9:0] n, logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; num = n; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(logic [9:0] n, logic [31:0] exp, string req);
    @(posedge clk); #1;
    num = n;
    @(negedge clk);
    check(req, 64'(rdata), 64'(exp));
  endtask

  task automatic dec(logic [33:0] a, logic eh, logic [1:0] eb, logic [33:0] eo, string req);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    check(req, 64'({hit, bank, off}), 64'({eh, eb, eo}));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(10'h040, 32'h0, "R1 bank0 after reset");
    rd(10'h043, 32'h0, "R1 bank3 after reset");
    rd(10'h010, 32'h0, "R1 index after reset");
    dec(34'h0, 1'b0, 2'd0, 34'h0, "R1 no hit after reset");

    // R13 write visible only after capturing edge; R2 mask; R4 high base
    @(posedge clk); #1;
    we = 1'b1; num = 10'h040; wdata = 32'hFFFF_FFFF; addr = 34'h3_FF80_0010;
    @(negedge clk);
    check("R13 decode before edge", 64'(hit), 64'd0);
    check("R13 readback before edge", 64'(rdata), 64'h0);
    @(posedge clk); #1;
    we = 1'b0;
    @(negedge clk);
    check("R13 decode after edge", 64'({hit, bank, off}), 64'({1'b1, 2'd0, 34'h10}));
    rd(10'h040, 32'hFFE0_FFC1, "R2 masked readback");
    dec(34'h3_FF7F_FFFF, 1'b0, 2'd0, 34'h0, "R4 below high base");

    // R3 enable cleared
    wr(10'h040, 32'hFFE0_FFC0);
    rd(10'h040, 32'hFFE0_FFC0, "R3 disabled word readback");
    dec(34'h3_FF80_0010, 1'b0, 2'd0, 34'h0, "R3 disabled no hit");

    // R6 / R5 zero size
    wr(10'h040, 32'h0000_0001);
    rd(10'h040, 32'h0, "R6 zero size reads zero");
    dec(34'h0, 1'b0, 2'd0, 34'h0, "R5 zero size no hit");

    // R5 8 MiB window edges
    wr(10'h040, 32'h0000_FFC1);
    dec(34'h0_007F_FFFF, 1'b1, 2'd0, 34'h7F_FFFF, "R5 last byte 8MiB");
    dec(34'h0_0080_0000, 1'b0, 2'd0, 34'h0, "R5 past 8MiB");

    // R11 bank1 through data window, 16 MiB
    wr(10'h010, 32'h1);
    wr(10'h011, 32'h0800_FF81);
    rd(10'h041, 32'h0800_FF81, "R11 direct view of indirect write");
    rd(10'h011, 32'h0800_FF81, "R11 indirect read");
    dec(34'h0_20FF_FFFF, 1'b1, 2'd1, 34'hFF_FFFF, "R5 bank1 last byte");
    dec(34'h0_2100_0000, 1'b0, 2'd0, 34'h0, "R5 bank1 past end");

    // R4 bank above 4 GiB, 64 MiB
    wr(10'h042, 32'hC000_FF01);
    dec(34'h3_0000_0004, 1'b1, 2'd2, 34'h4, "R4 bank2 above 4GiB");
    dec(34'h3_0400_0000, 1'b0, 2'd0, 34'h0, "R5 bank2 past end");

    // R7 overlapping full-space bank3
    wr(10'h043, 32'h0000_0141);
    dec(34'h1_0000_0000, 1'b1, 2'd3, 34'h1_0000_0000, "R5 full space window");
    dec(34'h0_0000_0010, 1'b1, 2'd0, 34'h10, "R7 bank0 over bank3");
    dec(34'h0_2000_0008, 1'b1, 2'd1, 34'h8, "R7 bank1 over bank3");
    dec(34'h3_0400_0000, 1'b1, 2'd3, 34'h3_0400_0000, "R8 offset full window");

    // random addresses compared by the model each cycle
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #1;
      case (k % 4)
        0: addr = {2'($urandom_range(3, 0)), 32'($urandom())};
        1: addr = 34'h0_2000_0000 + 34'($urandom_range(32'h0200_0000, 0));
        2: addr = 34'h3_0000_0000 + 34'($urandom_range(32'h0500_0000, 0));
        default: addr = 34'($urandom_range(32'h00A0_0000, 0));
      endcase
    end

    // R10 / R9 DDR word and index width
    wr(10'h010, 32'hE1);
    rd(10'h011, 32'h2000_0000, "R10 DDR mode word");
    wr(10'h011, 32'h0);
    rd(10'h011, 32'h2000_0000, "R10 DDR word ignores write");
    rd(10'h010, 32'hE1, "R9 index readback");
    wr(10'h010, 32'h0000_01E1);
    rd(10'h010, 32'hE1, "R9 index keeps low 8 bits");

    // R11 disable bank3 through window
    wr(10'h010, 32'h3);
    wr(10'h011, 32'h0);
    dec(34'h1_0000_0000, 1'b0, 2'd0, 34'h0, "R11 bank3 cleared via window");

    // R12 unmapped index and register numbers
    wr(10'h010, 32'h55);
    rd(10'h011, 32'h0, "R12 unmapped index reads zero");
    wr(10'h011, 32'hFFFF_FFFF);
    rd(10'h011, 32'h0, "R12 unmapped index ignores write");
    wr(10'h044, 32'hFFFF_FFFF);
    rd(10'h044, 32'h0, "R12 unmapped number reads zero");
    rd(10'h040, 32'h0000_FFC1, "R12 bank0 untouched");
    rd(10'h042, 32'hC000_FF01, "R12 bank2 untouched");
    dec(34'h0_0000_0010, 1'b1, 2'd0, 34'h10, "R12 decode untouched");

    // R1 reset mid-run
    @(posedge clk); #1;
    rst_n = 1'b0; num = 10'h042; addr = 34'h3_0000_0004;
    @(negedge clk);
    check("R1 bank2 cleared by reset", 64'(rdata), 64'h0);
    check("R1 no hit in reset", 64'(hit), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd(10'h010, 32'h0, "R1 index cleared by reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule